// File: doc/BRIEF.md
# Multi-Cycle Instruction Bus Sequencer

This block is the control unit of a small 8-bit processor with a 16-bit address space. It breaks every instruction into an ordered series of machine cycles and hands each one, as a request, to an external bus cycle engine. It waits until the engine reports completion, then captures the returned byte. The unit holds a program counter, a stack pointer, a paired H/L register and an accumulator.

Four instructions are understood: a no-operation, an absolute jump, an accumulator load through the H/L pair, and a pop of H/L from the stack. Every other opcode is executed as a no-operation. There is no overlap between instructions, so each instruction ends before the next opcode fetch begins. A machine-cycle counter is brought out so that the cost of each instruction can be observed.

Top module: `instrSequencer`

## Requirements
- R1: While rstN is low, busReq is 0, pcOut is 0, spOut equals SP_INIT (default 16'hFFF0), hlOut is 0, accOut is 0 and mcCount is 0. On the first clock after release busReq rises, and that first request is an opcode fetch (busFetch=1) at address 0.
- R2: After reset busReq stays at 1. busAddr and busFetch hold steady until busDone is seen at a clock edge. Each such completion adds exactly one to mcCount, and the next machine cycle is presented from the following clock.
- R3: Opcode 8'h00 takes one fetch cycle and adds 1 to pcOut. The next fetch is at the following address.
- R4: Any opcode other than 8'h00, 8'hC3, 8'h7E and 8'hE1 behaves exactly like 8'h00.
- R5: Opcode 8'hC3 takes a fetch followed by two read cycles at the next two program addresses. The first byte read is the low half of the target and the second is the high half. pcOut becomes {high, low}.
- R6: The architectural registers (pcOut, spOut, hlOut, accOut) change only on the clock edge that completes a machine cycle. During a jump, pcOut is replaced by the target only when the second operand byte completes.
- R7: Opcode 8'h7E takes a fetch and one read at the address held in hlOut. The byte returned goes to accOut. spOut and hlOut are left unchanged.
- R8: Opcode 8'hE1 takes a fetch and two reads: the first at spOut, which goes into the low byte of hlOut, and the second at spOut+1, which goes into the high byte. spOut then grows by 2.
- R9: When the engine takes four clocks per machine cycle, instructions last as follows. No-operation: 4 clocks. Load: 8 clocks. Pop: 12 clocks. Jump: 12 clocks.
- R10: busFetch is 1 only during opcode fetch cycles. Operand and data reads present busFetch=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | output | 1 | A machine cycle is being requested |
| busFetch | output | 1 | 1 for an opcode fetch, 0 for a data or operand read |
| busAddr | output | 16 | Address of the current machine cycle |
| busDone | input | 1 | Engine completes the current machine cycle this clock |
| busRdata | input | 8 | Byte returned with busDone |
| pcOut | output | 16 | Program counter |
| spOut | output | 16 | Stack pointer |
| hlOut | output | 16 | H/L register pair, H in the upper byte |
| accOut | output | 8 | Accumulator |
| mcCount | output | MC_W | Completed machine cycles since reset |

## Verification
A short program is run against a bench-side bus engine that takes four clocks per cycle. The program contains every opcode at least once, plus an unknown opcode. Two pops from successive stack positions show that the stack pointer steps by two and that the low and high bytes land in the right halves. Each is followed by a load through the freshly popped pair, which separates an address taken from H/L from one taken from the stack or the program counter. One jump target has a nonzero high byte, so a swapped operand order would land somewhere else. A reset applied partway through a cycle shows that the unit returns to a clean fetch at address 0.

// File: rtl/instrSeqPkg.sv
package instrSeqPkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2 * DATA_W;

  localparam logic [DATA_W-1:0] OP_NOP  = 8'h00;
  localparam logic [DATA_W-1:0] OP_JUMP = 8'hC3;
  localparam logic [DATA_W-1:0] OP_LDHL = 8'h7E;
  localparam logic [DATA_W-1:0] OP_POP  = 8'hE1;

  typedef enum logic [1:0] {
    SEL_PC  = 2'd0,
    SEL_HL  = 2'd1,
    SEL_SP  = 2'd2,
    SEL_SP1 = 2'd3
  } addrSel_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_JLO   = 3'd1,
    ST_JHI   = 3'd2,
    ST_LDA   = 3'd3,
    ST_POPL  = 3'd4,
    ST_POPH  = 3'd5
  } seqState_e;

  typedef struct packed {
    logic     pcInc;
    logic     pcLoad;
    logic     tmpLoad;
    logic     accLoad;
    logic     lLoad;
    logic     hLoad;
    logic     spStep;
    logic     mcInc;
    addrSel_e addrSel;
  } ctlStrobes_t;
endpackage

// File: rtl/seqControl.sv
module seqControl
  import instrSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busReq,
  output logic              busFetch,
  output ctlStrobes_t       ctl
);
  seqState_e stateQ, stateD;
  logic reqOnQ;
  logic doneOk;

  assign doneOk   = busDone & reqOnQ;
  assign busReq   = reqOnQ;
  assign busFetch = (stateQ == ST_FETCH);

  always_comb begin
    ctl       = '0;
    stateD    = stateQ;
    ctl.mcInc = doneOk;
    unique case (stateQ)
      ST_LDA:  ctl.addrSel = SEL_HL;
      ST_POPL: ctl.addrSel = SEL_SP;
      ST_POPH: ctl.addrSel = SEL_SP1;
      default: ctl.addrSel = SEL_PC;
    endcase
    if (doneOk) begin
      unique case (stateQ)
        ST_FETCH: begin
          ctl.pcInc = 1'b1;
          if (busRdata == OP_JUMP)      stateD = ST_JLO;
          else if (busRdata == OP_LDHL) stateD = ST_LDA;
          else if (busRdata == OP_POP)  stateD = ST_POPL;
          else                          stateD = ST_FETCH;
        end
        ST_JLO: begin
          ctl.pcInc   = 1'b1;
          ctl.tmpLoad = 1'b1;
          stateD      = ST_JHI;
        end
        ST_JHI: begin
          ctl.pcLoad = 1'b1;
          stateD     = ST_FETCH;
        end
        ST_LDA: begin
          ctl.accLoad = 1'b1;
          stateD      = ST_FETCH;
        end
        ST_POPL: begin
          ctl.lLoad = 1'b1;
          stateD    = ST_POPH;
        end
        ST_POPH: begin
          ctl.hLoad  = 1'b1;
          ctl.spStep = 1'b1;
          stateD     = ST_FETCH;
        end
        default: stateD = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_FETCH;
      reqOnQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      reqOnQ <= 1'b1;
    end
  end
endmodule

// File: rtl/seqDatapath.sv
module seqDatapath
  import instrSeqPkg::*;
#(
  parameter int unsigned       MC_W    = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] hlOut,
  output logic [DATA_W-1:0] accOut,
  output logic [MC_W-1:0]   mcCount
);
  logic [ADDR_W-1:0] pcQ, spQ;
  logic [DATA_W-1:0] hQ, lQ, accQ, tmpQ;
  logic [MC_W-1:0]   mcQ;

  always_comb begin
    unique case (ctl.addrSel)
      SEL_HL:  busAddr = {hQ, lQ};
      SEL_SP:  busAddr = spQ;
      SEL_SP1: busAddr = spQ + ADDR_W'(1);
      default: busAddr = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= '0;
      spQ  <= SP_INIT;
      hQ   <= '0;
      lQ   <= '0;
      accQ <= '0;
      tmpQ <= '0;
      mcQ  <= '0;
    end else begin
      if (ctl.pcLoad)      pcQ <= {busRdata, tmpQ};
      else if (ctl.pcInc)  pcQ <= pcQ + ADDR_W'(1);
      if (ctl.tmpLoad)     tmpQ <= busRdata;
      if (ctl.accLoad)     accQ <= busRdata;
      if (ctl.lLoad)       lQ <= busRdata;
      if (ctl.hLoad)       hQ <= busRdata;
      if (ctl.spStep)      spQ <= spQ + ADDR_W'(2);
      if (ctl.mcInc)       mcQ <= mcQ + MC_W'(1);
    end
  end

  assign pcOut   = pcQ;
  assign spOut   = spQ;
  assign hlOut   = {hQ, lQ};
  assign accOut  = accQ;
  assign mcCount = mcQ;
endmodule

// File: rtl/instrSequencer.sv
module instrSequencer
  import instrSeqPkg::*;
#(
  parameter int unsigned       MC_W    = 16,
  parameter logic [ADDR_W-1:0] SP_INIT = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              busReq,
  output logic              busFetch,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] hlOut,
  output logic [DATA_W-1:0] accOut,
  output logic [MC_W-1:0]   mcCount
);
  ctlStrobes_t ctl;

  seqControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busDone  (busDone),
    .busRdata (busRdata),
    .busReq   (busReq),
    .busFetch (busFetch),
    .ctl      (ctl)
  );

  seqDatapath #(.MC_W(MC_W), .SP_INIT(SP_INIT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .busRdata (busRdata),
    .busAddr  (busAddr),
    .pcOut    (pcOut),
    .spOut    (spOut),
    .hlOut    (hlOut),
    .accOut   (accOut),
    .mcCount  (mcCount)
  );
endmodule

// File: rtl/instrSequencerChecker.sv
module instrSequencerChecker
  import instrSeqPkg::*;
#(
  parameter int unsigned MC_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busFetch,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDone,
  input logic [DATA_W-1:0] busRdata,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] spOut,
  input logic [ADDR_W-1:0] hlOut,
  input logic [DATA_W-1:0] accOut,
  input logic [MC_W-1:0]   mcCount
);
  logic doneSeen;
  assign doneSeen = busReq && busDone;

  a_r1_req_up: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> busReq);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> ($stable(busAddr) && $stable(busFetch)));

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |=> (mcCount == $past(mcCount) + MC_W'(1)));

  a_r2_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    !doneSeen |=> $stable(mcCount));

  a_r6_regs_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !doneSeen |=> ($stable(pcOut) && $stable(spOut) && $stable(hlOut) && $stable(accOut)));

  a_r3_nop_next: assert property (@(posedge clk) disable iff (!rstN)
    (doneSeen && busFetch && busRdata == 8'h00) |=>
      (busFetch && busAddr == $past(busAddr) + ADDR_W'(1)));

  a_r7_load_addr: assert property (@(posedge clk) disable iff (!rstN)
    (doneSeen && busFetch && busRdata == 8'h7E) |=> (!busFetch && busAddr == hlOut));

  a_r8_pop_addr: assert property (@(posedge clk) disable iff (!rstN)
    (doneSeen && busFetch && busRdata == 8'hE1) |=> (!busFetch && busAddr == spOut));

  a_r8_sp_step: assert property (@(posedge clk) disable iff (!rstN)
    doneSeen |=> (spOut == $past(spOut) || spOut == $past(spOut) + ADDR_W'(2)));
endmodule

bind instrSequencer instrSequencerChecker #(.MC_W(MC_W)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busFetch(busFetch),
  .busAddr(busAddr), .busDone(busDone), .busRdata(busRdata),
  .pcOut(pcOut), .spOut(spOut), .hlOut(hlOut), .accOut(accOut),
  .mcCount(mcCount)
);

// File: tb/instrSequencer_bench.sv
`timescale 1ns/1ps
module instrSequencer_bench;
  localparam int TSTATES = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq, busFetch, busDone;
  logic [15:0] busAddr, pcOut, spOut, hlOut;
  logic [7:0]  busRdata, accOut;
  logic [15:0] mcCount;

  always #5 clk = ~clk;

  instrSequencer u_instrSequencer (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busFetch(busFetch),
    .busAddr(busAddr), .busDone(busDone), .busRdata(busRdata),
    .pcOut(pcOut), .spOut(spOut), .hlOut(hlOut), .accOut(accOut),
    .mcCount(mcCount)
  );

  int checks = 0;
  int fails = 0;
  int clkCnt = 0;
  logic finished = 1'b0;
  logic stabErr = 1'b0;
  logic [7:0]  mem [0:255];
  logic [15:0] seenAddr [0:3];
  logic        seenFetch [0:3];

  always @(posedge clk) clkCnt <= clkCnt + 1;

  typedef struct packed {
    logic [7:0]  ncyc;
    logic [15:0] pc;
    logic [15:0] sp;
    logic [15:0] hl;
    logic [7:0]  acc;
    logic [15:0] a1;
    logic [15:0] a2;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{8'd1, 16'h0001, 16'hFFF0, 16'h0000, 8'h00, 16'h0000, 16'h0000},
    '{8'd3, 16'h0002, 16'hFFF2, 16'h1234, 8'h00, 16'hFFF0, 16'hFFF1},
    '{8'd2, 16'h0003, 16'hFFF2, 16'h1234, 8'hA5, 16'h1234, 16'h0000},
    '{8'd3, 16'h0040, 16'hFFF2, 16'h1234, 8'hA5, 16'h0004, 16'h0005},
    '{8'd1, 16'h0041, 16'hFFF2, 16'h1234, 8'hA5, 16'h0000, 16'h0000},
    '{8'd3, 16'h0042, 16'hFFF4, 16'h5678, 8'hA5, 16'hFFF2, 16'hFFF3},
    '{8'd2, 16'h0043, 16'hFFF4, 16'h5678, 8'h3C, 16'h5678, 16'h0000},
    '{8'd3, 16'h0180, 16'hFFF4, 16'h5678, 8'h3C, 16'h0044, 16'h0045},
    '{8'd1, 16'h0181, 16'hFFF4, 16'h5678, 8'h3C, 16'h0000, 16'h0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Serve one machine cycle; starts and ends on a falling edge.
  task automatic serveCycle(input int idx);
    seenAddr[idx]  = busAddr;
    seenFetch[idx] = busFetch;
    repeat (TSTATES - 1) begin
      @(negedge clk);
      if (busAddr !== seenAddr[idx] || busFetch !== seenFetch[idx] || busReq !== 1'b1)
        stabErr = 1'b1;
    end
    busDone  = 1'b1;
    busRdata = mem[seenAddr[idx][7:0]];
    @(negedge clk);
    busDone  = 1'b0;
    busRdata = 8'h00;
  endtask

  task automatic runInstr(output int n, output int clks);
    int start;
    start = clkCnt;
    n = 0;
    do begin
      serveCycle(n);
      n++;
    end while (!busFetch && n < 4);
    clks = clkCnt - start;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h01] = 8'hE1; mem[8'h02] = 8'h7E;
    mem[8'h03] = 8'hC3; mem[8'h04] = 8'h40; mem[8'h05] = 8'h00;
    mem[8'h40] = 8'h55; mem[8'h41] = 8'hE1; mem[8'h42] = 8'h7E;
    mem[8'h43] = 8'hC3; mem[8'h44] = 8'h80; mem[8'h45] = 8'h01;
    mem[8'hF0] = 8'h34; mem[8'hF1] = 8'h12;
    mem[8'hF2] = 8'h78; mem[8'hF3] = 8'h56;
    mem[8'h34] = 8'hA5; mem[8'h78] = 8'h3C;
  end

  initial begin
    int n, clks;
    logic [15:0] mcBefore, pcBefore;
    busDone = 1'b0;
    busRdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busReq in reset", {31'b0, busReq}, 32'd0);
    check("R1 pc", {16'b0, pcOut}, 32'h0000);
    check("R1 sp", {16'b0, spOut}, 32'hFFF0);
    check("R1 hl", {16'b0, hlOut}, 32'h0000);
    check("R1 acc", {24'b0, accOut}, 32'h00);
    check("R1 mcCount", {16'b0, mcCount}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first request", {31'b0, busReq}, 32'd1);
    check("R1 first fetch kind", {31'b0, busFetch}, 32'd1);
    check("R1 first fetch addr", {16'b0, busAddr}, 32'h0000);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R10 R2
    for (int v = 0; v < NVEC; v++) begin
      mcBefore = mcCount;
      pcBefore = pcOut;
      runInstr(n, clks);
      check($sformatf("R3/R4/R5/R7/R8 cycles vec%0d", v), n, VECS[v].ncyc);
      check($sformatf("R9 clocks vec%0d", v), clks, VECS[v].ncyc * TSTATES);
      check($sformatf("R2 mcCount delta vec%0d", v), 32'(mcCount - mcBefore), VECS[v].ncyc);
      check($sformatf("R10 fetch addr vec%0d", v), {15'b0, seenFetch[0], seenAddr[0]}, {15'b0, 1'b1, pcBefore});
      if (VECS[v].ncyc > 1)
        check($sformatf("R10 R5 R7 R8 second cycle vec%0d", v), {15'b0, seenFetch[1], seenAddr[1]}, {16'b0, VECS[v].a1});
      if (VECS[v].ncyc > 2)
        check($sformatf("R5 R8 third cycle vec%0d", v), {15'b0, seenFetch[2], seenAddr[2]}, {16'b0, VECS[v].a2});
      check($sformatf("R5 R6 pc vec%0d", v), {16'b0, pcOut}, {16'b0, VECS[v].pc});
      check($sformatf("R8 sp vec%0d", v), {16'b0, spOut}, {16'b0, VECS[v].sp});
      check($sformatf("R8 hl vec%0d", v), {16'b0, hlOut}, {16'b0, VECS[v].hl});
      check($sformatf("R7 acc vec%0d", v), {24'b0, accOut}, {24'b0, VECS[v].acc});
    end
    check("R2 address held until done", {31'b0, stabErr}, 32'd0);

    // R6: pc untouched while a cycle is still pending
    @(negedge clk);
    check("R6 pc still during wait", {16'b0, pcOut}, 32'h0181);

    // R1: reset in the middle of a cycle
    rstN = 1'b0;
    @(negedge clk);
    check("R1 mid-cycle reset pc", {16'b0, pcOut}, 32'h0000);
    check("R1 mid-cycle reset sp", {16'b0, spOut}, 32'hFFF0);
    check("R1 mid-cycle reset hl", {16'b0, hlOut}, 32'h0000);
    check("R1 mid-cycle reset mcCount", {16'b0, mcCount}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 restart fetch at 0", {15'b0, busFetch, busAddr}, {15'b0, 1'b1, 16'h0000});
    runInstr(n, clks);
    check("R3 nop after restart pc", {16'b0, pcOut}, 32'h0001);
    check("R2 mcCount after restart", {16'b0, mcCount}, 32'd1);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule